// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block gathers the event sources of a UART with infrared sub-modes and presents them to a host processor in two register views. In the legacy view it works as a priority encoder. It returns a 4-bit code for the single most urgent source that is both pending and enabled, and it clears each source when the host makes the matching access. In the extended view every source has its own flag bit in an 8-bit map. A flag is set whether or not it is enabled, and the interrupt line is formed by masking the map with the enable byte.

The host supplies one-cycle access strobes: a read of the identification register, a read of line status, a read of modem status, a read of the receive data port and a write of the transmit data port. It also supplies per-bit acknowledges for the four auxiliary extended flags. The surrounding UART supplies event strobes and FIFO levels. For the receive idle time-out it supplies a character-time tick. The FIFOs, the line coding and the DMA engine sit outside this block.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the extended view reads 0x02, because only the transmit flag is set. With an all-zero enable byte, the legacy view reads 0x01 and `irq` is low.
- R2: Legacy codes are: link status 0110, receive data 0100, receive time-out 1100, transmit empty 0010, modem status 0000, and none 0001. Priority from highest to lowest is link status, then receive data, then time-out, then transmit empty, then modem status.
- R3: In the legacy view, enable bit 0 gates both receive data and time-out. Bit 1 gates transmit, bit 2 gates link status and bit 3 gates modem status. A disabled source never appears in the code, and bits 7:4 of the legacy read value are zero.
- R4: The link-status flag is set according to `ir_mode`. Value 0 (UART) sets it on a character error or an overrun. Value 1 (high-speed IR) sets it on frame end, overrun, underrun or transmit halt. Values 2 and 3 (consumer IR) set it on overrun or underrun only. A line-status read clears it.
- R5: The receive-data flag is set on a rising edge of `rx_above`. It is cleared by a receive-data read, or whenever `rx_above` is low.
- R6: With `fifo_on` high, the time-out flag is set on the `TO_CHARS`-th (default 4) `char_tick` in a row during which the receive FIFO is non-empty and has seen no push or pop. Any activity, an empty FIFO or `fifo_on` low restarts the count. A receive-data read clears the flag.
- R7: The transmit flag is set on a rising edge of `tx_below`. It is cleared by a transmit-data write, or by a legacy identification read that returned 0010. A legacy read that returns any other code leaves it set.
- R8: The modem-status flag is set by `modem_chg` and cleared by a modem-status read.
- R9: Extended map bits are: 0 receive data (or time-out when `fifo_on`), 1 transmit, 2 link status, 3 modem, 4 DMA, 5 PLD event, 6 status-FIFO event, 7 timer. Each flag is set regardless of the enable byte.
- R10: In the legacy view `irq` is high exactly when the code differs from 0001. In the extended view `irq` is the OR of map AND enable.
- R11: When `dma_rd_clr` is high, an extended identification read clears bit 4. `side_ack` bits 0 to 3 clear map bits 4 to 7 respectively.
- R12: When a set event and a clearing access fall in the same cycle, the flag stays set.
- R13: `rd_data` takes the view selected by `ext_mode` on the clock edge where `rd_id` is high, and holds that value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1 selects the extended bitmap view |
| fifo_on | input | 1 | FIFOs enabled |
| ir_mode | input | 2 | Link-status sub-mode: 0 UART, 1 high-speed IR, 2/3 consumer IR |
| dma_rd_clr | input | 1 | Extended read clears the DMA flag |
| ier | input | 8 | Interrupt enable byte |
| lnk_char_err | input | 1 | Parity, framing or break reported |
| lnk_overrun | input | 1 | Receive overrun strobe |
| lnk_frame_end | input | 1 | Last frame byte at FIFO bottom |
| lnk_underrun | input | 1 | Transmit underrun strobe |
| lnk_tx_halt | input | 1 | Transmitter halted at frame end |
| rx_above | input | 1 | Receive level at or above threshold (holding register full) |
| tx_below | input | 1 | Transmit level below threshold (holding register empty) |
| rx_nonempty | input | 1 | Receive FIFO holds at least one character |
| rx_activity | input | 1 | Character pushed to or popped from receive FIFO |
| char_tick | input | 1 | One pulse per character time |
| modem_chg | input | 1 | Modem line change strobe |
| dma_ev | input | 1 | DMA event strobe |
| pld_ev | input | 1 | PLD event strobe |
| sfif_ev | input | 1 | Status FIFO event strobe |
| tmr_ev | input | 1 | Timer event strobe |
| rd_id | input | 1 | Identification register read |
| rd_lsr | input | 1 | Line status read |
| rd_msr | input | 1 | Modem status read |
| rd_rxd | input | 1 | Receive data read |
| wr_txd | input | 1 | Transmit data write |
| side_ack | input | 4 | Acknowledges for map bits 4..7 |
| rd_data | output | 8 | Registered identification read value |
| irq | output | 1 | Interrupt request |

## Verification
Two situations can land in one cycle: a source being set, and the access that would clear it. The bench drives `modem_chg` together with a modem-status read, and `dma_ev` together with its acknowledge, in the same clock. It then expects the next identification read to still report the source. A second overlap is a legacy identification read while transmit empty is pending under a higher source. Here the bench checks that the read returns the higher code and leaves transmit empty pending for a later read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_NONE = 4'b0001,
    ID_LS   = 4'b0110,
    ID_RX   = 4'b0100,
    ID_TO   = 4'b1100,
    ID_TX   = 4'b0010,
    ID_MS   = 4'b0000
  } id_code_e;

  typedef enum logic [1:0] {
    IRM_UART = 2'd0,
    IRM_FAST = 2'd1,
    IRM_CIR  = 2'd2,
    IRM_CIR2 = 2'd3
  } ir_mode_e;

  localparam int unsigned FL_RX  = 0;
  localparam int unsigned FL_TX  = 1;
  localparam int unsigned FL_LS  = 2;
  localparam int unsigned FL_MS  = 3;
  localparam int unsigned FL_DMA = 4;
  localparam int unsigned FL_PLD = 5;
  localparam int unsigned FL_SF  = 6;
  localparam int unsigned FL_TM  = 7;
  localparam int unsigned FL_TO  = 8;
  localparam int unsigned NFLAG  = 9;
  localparam logic [NFLAG-1:0] FLAG_RST = 9'h002;

endpackage

// File: rtl/uart_irq_flagbank.sv
module uart_irq_flagbank #(
  parameter int unsigned   N       = 9,
  parameter logic [N-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  logic [N-1:0] q_nxt;

  // set dominates clear so a coincident event is never dropped
  always_comb begin
    q_nxt = set | (q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
    p_ack_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !q[i]);
  end

endmodule

// File: rtl/uart_irq_rxtmo.sv
module uart_irq_rxtmo #(
  parameter int unsigned CHARS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic nonempty,
  input  logic activity,
  input  logic tick,
  output logic hit
);

  localparam int unsigned CW = $clog2(CHARS + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(CHARS);
  localparam logic [CW-1:0] CNT_LAST = CW'(CHARS - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          cnt_en, idle_ok;

  always_comb begin
    idle_ok = enable & nonempty & ~activity;
    cnt_en  = ~idle_ok | (tick & (cnt_q != CNT_MAX));
    cnt_nxt = idle_ok ? cnt_q + 1'b1 : '0;
    hit     = idle_ok & tick & (cnt_q == CNT_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  p_to_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(nonempty));

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic     ls,
  input  logic     rx,
  input  logic     to,
  input  logic     tx,
  input  logic     ms,
  output id_code_e code
);

  always_comb begin
    if (ls)      code = ID_LS;
    else if (rx) code = ID_RX;
    else if (to) code = ID_TO;
    else if (tx) code = ID_TX;
    else if (ms) code = ID_MS;
    else         code = ID_NONE;
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned TO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_mode,
  input  logic       fifo_on,
  input  logic [1:0] ir_mode,
  input  logic       dma_rd_clr,
  input  logic [7:0] ier,
  input  logic       lnk_char_err,
  input  logic       lnk_overrun,
  input  logic       lnk_frame_end,
  input  logic       lnk_underrun,
  input  logic       lnk_tx_halt,
  input  logic       rx_above,
  input  logic       tx_below,
  input  logic       rx_nonempty,
  input  logic       rx_activity,
  input  logic       char_tick,
  input  logic       modem_chg,
  input  logic       dma_ev,
  input  logic       pld_ev,
  input  logic       sfif_ev,
  input  logic       tmr_ev,
  input  logic       rd_id,
  input  logic       rd_lsr,
  input  logic       rd_msr,
  input  logic       rd_rxd,
  input  logic       wr_txd,
  input  logic [3:0] side_ack,
  output logic [7:0] rd_data,
  output logic       irq
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // level edge detectors
  logic rx_above_q, tx_below_q, rx_rise, tx_rise;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rx_above_q <= 1'b0;
      tx_below_q <= 1'b1;
    end else begin
      rx_above_q <= rx_above;
      tx_below_q <= tx_below;
    end
  end

  assign rx_rise = rx_above & ~rx_above_q;
  assign tx_rise = tx_below & ~tx_below_q;

  // link-status event selection per sub-mode
  logic ls_set;

  always_comb begin
    case (ir_mode_e'(ir_mode))
      IRM_UART: ls_set = lnk_char_err | lnk_overrun;
      IRM_FAST: ls_set = lnk_frame_end | lnk_overrun | lnk_underrun | lnk_tx_halt;
      default:  ls_set = lnk_overrun | lnk_underrun;
    endcase
  end

  // receive idle time-out
  logic to_hit;

  uart_irq_rxtmo #(.CHARS(TO_CHARS)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .enable   (fifo_on),
    .nonempty (rx_nonempty),
    .activity (rx_activity),
    .tick     (char_tick),
    .hit      (to_hit)
  );

  // flag storage
  logic [NFLAG-1:0] fl, fl_set, fl_clr;
  id_code_e         code;
  logic             id_rd_leg, id_rd_ext;

  assign id_rd_leg = rd_id & ~ext_mode;
  assign id_rd_ext = rd_id &  ext_mode;

  always_comb begin
    fl_set          = '0;
    fl_set[FL_RX]   = rx_rise;
    fl_set[FL_TX]   = tx_rise;
    fl_set[FL_LS]   = ls_set;
    fl_set[FL_MS]   = modem_chg;
    fl_set[FL_DMA]  = dma_ev;
    fl_set[FL_PLD]  = pld_ev;
    fl_set[FL_SF]   = sfif_ev;
    fl_set[FL_TM]   = tmr_ev;
    fl_set[FL_TO]   = to_hit;

    fl_clr          = '0;
    fl_clr[FL_RX]   = rd_rxd | ~rx_above;
    fl_clr[FL_TX]   = wr_txd | (id_rd_leg & (code == ID_TX));
    fl_clr[FL_LS]   = rd_lsr;
    fl_clr[FL_MS]   = rd_msr;
    fl_clr[FL_DMA]  = side_ack[0] | (id_rd_ext & dma_rd_clr);
    fl_clr[FL_PLD]  = side_ack[1];
    fl_clr[FL_SF]   = side_ack[2];
    fl_clr[FL_TM]   = side_ack[3];
    fl_clr[FL_TO]   = rd_rxd;
  end

  uart_irq_flagbank #(.N(NFLAG), .RST_VAL(FLAG_RST)) u_flags (
    .clk   (clk),
    .rst_n (rst_i_n),
    .set   (fl_set),
    .clr   (fl_clr),
    .q     (fl)
  );

  // legacy priority encoder on enabled flags
  uart_irq_prio u_prio (
    .ls   (fl[FL_LS] & ier[2]),
    .rx   (fl[FL_RX] & ier[0]),
    .to   (fl[FL_TO] & ier[0]),
    .tx   (fl[FL_TX] & ier[1]),
    .ms   (fl[FL_MS] & ier[3]),
    .code (code)
  );

  // views
  logic [7:0] ext_map, view;

  always_comb begin
    ext_map = {fl[FL_TM], fl[FL_SF], fl[FL_PLD], fl[FL_DMA],
               fl[FL_MS], fl[FL_LS], fl[FL_TX],
               fl[FL_RX] | (fifo_on & fl[FL_TO])};
    view    = ext_mode ? ext_map : {4'h0, code};
    irq     = ext_mode ? |(ext_map & ier) : (code != ID_NONE);
  end

  // read value captured on the read strobe
  logic [7:0] rd_data_q, rd_data_nxt;
  logic       rd_en;

  always_comb begin
    rd_en       = rd_id;
    rd_data_nxt = view;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   rd_data_q <= 8'h00;
    else if (rd_en) rd_data_q <= rd_data_nxt;
  end

  assign rd_data = rd_data_q;

  p_ls_top_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!ext_mode && ier[2] && fl[FL_LS]) |-> (code == ID_LS));

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_id && !ext_mode) |=> (rd_data[7:4] == 4'h0));

  p_tx_idclr_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (id_rd_leg && code == ID_TX && !tx_rise) |=> !fl[FL_TX]);

  p_mask_quiet_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ext_mode && ier == 8'h00) |-> !irq);

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_id |=> $stable(rd_data));

endmodule

// File: tb/uart_irq_ident_tb.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_mode, fifo_on, dma_rd_clr;
  logic [1:0] ir_mode;
  logic [7:0] ier;
  logic       lnk_char_err, lnk_overrun, lnk_frame_end, lnk_underrun, lnk_tx_halt;
  logic       rx_above, tx_below, rx_nonempty, rx_activity, char_tick;
  logic       modem_chg, dma_ev, pld_ev, sfif_ev, tmr_ev;
  logic       rd_id, rd_lsr, rd_msr, rd_rxd, wr_txd;
  logic [3:0] side_ack;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  uart_irq_ident dut_i (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .fifo_on(fifo_on),
    .ir_mode(ir_mode), .dma_rd_clr(dma_rd_clr), .ier(ier),
    .lnk_char_err(lnk_char_err), .lnk_overrun(lnk_overrun),
    .lnk_frame_end(lnk_frame_end), .lnk_underrun(lnk_underrun),
    .lnk_tx_halt(lnk_tx_halt), .rx_above(rx_above), .tx_below(tx_below),
    .rx_nonempty(rx_nonempty), .rx_activity(rx_activity), .char_tick(char_tick),
    .modem_chg(modem_chg), .dma_ev(dma_ev), .pld_ev(pld_ev), .sfif_ev(sfif_ev),
    .tmr_ev(tmr_ev), .rd_id(rd_id), .rd_lsr(rd_lsr), .rd_msr(rd_msr),
    .rd_rxd(rd_rxd), .wr_txd(wr_txd), .side_ack(side_ack),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_chk(input string tag, input logic [7:0] exp);
    rd_id = 1'b1; tick(); rd_id = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  task automatic t_reset();
    ext_mode = 1'b1; ier = 8'h00; tick();
    read_chk("R1 ext view after reset", 8'h02);
    ext_mode = 1'b0; tick();
    read_chk("R1 legacy view, nothing enabled", 8'h01);
    chk("R1 irq low after reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_priority();
    ier = 8'h0F; tick();
    chk("R10 irq with tx pending", {7'd0, irq}, 8'h01);
    modem_chg = 1'b1; tick(); modem_chg = 1'b0;
    read_chk("R2 tx above modem", 8'h02);
    read_chk("R7 id read cleared tx, modem next", 8'h00);
    lnk_char_err = 1'b1; tick(); lnk_char_err = 1'b0;
    read_chk("R2 link status highest", 8'h06);
    rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
    read_chk("R8 modem still pending", 8'h00);
    rx_above = 1'b1; tick();
    read_chk("R2 rx above modem", 8'h04);
    rd_msr = 1'b1; tick(); rd_msr = 1'b0;
    read_chk("R8 msr read keeps rx", 8'h04);
    rd_rxd = 1'b1; tick(); rd_rxd = 1'b0;
    read_chk("R5 rxd read clears rx", 8'h01);
    chk("R10 irq low when code none", {7'd0, irq}, 8'h00);
    rx_above = 1'b0; tick();
  endtask

  task automatic t_tx_hold();
    tx_below = 1'b0; tick(); tx_below = 1'b1; tick();
    lnk_char_err = 1'b1; tick(); lnk_char_err = 1'b0;
    read_chk("R7 higher source reported", 8'h06);
    read_chk("R7 same read again", 8'h06);
    rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
    read_chk("R7 tx survived higher read", 8'h02);
    read_chk("R7 tx cleared by its own read", 8'h01);
    tx_below = 1'b0; tick(); tx_below = 1'b1; tick();
    wr_txd = 1'b1; tick(); wr_txd = 1'b0;
    read_chk("R7 txd write clears tx", 8'h01);
  endtask

  task automatic t_mask();
    ier = 8'h0B; tick();
    lnk_char_err = 1'b1; tick(); lnk_char_err = 1'b0;
    read_chk("R3 disabled link status hidden", 8'h01);
    chk("R3 irq low for disabled source", {7'd0, irq}, 8'h00);
    ext_mode = 1'b1; tick();
    read_chk("R9 flag set regardless of enable", 8'h04);
    rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
    read_chk("R4 lsr read clears link", 8'h00);
    ext_mode = 1'b0; tick();
  endtask

  task automatic t_submodes();
    ext_mode = 1'b1; ier = 8'h00; ir_mode = 2'd0; tick();
    lnk_frame_end = 1'b1; tick(); lnk_frame_end = 1'b0;
    read_chk("R4 uart ignores frame end", 8'h00);
    lnk_overrun = 1'b1; tick(); lnk_overrun = 1'b0;
    read_chk("R4 uart overrun", 8'h04);
    rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
    ir_mode = 2'd1; lnk_char_err = 1'b1; tick(); lnk_char_err = 1'b0;
    read_chk("R4 fast ir ignores char error", 8'h00);
    lnk_tx_halt = 1'b1; tick(); lnk_tx_halt = 1'b0;
    read_chk("R4 fast ir tx halt", 8'h04);
    rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
    lnk_frame_end = 1'b1; tick(); lnk_frame_end = 1'b0;
    read_chk("R4 fast ir frame end", 8'h04);
    rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
    ir_mode = 2'd2; lnk_frame_end = 1'b1; lnk_tx_halt = 1'b1; lnk_char_err = 1'b1; tick();
    lnk_frame_end = 1'b0; lnk_tx_halt = 1'b0; lnk_char_err = 1'b0;
    read_chk("R4 consumer ir ignores other events", 8'h00);
    lnk_underrun = 1'b1; tick(); lnk_underrun = 1'b0;
    read_chk("R4 consumer ir underrun", 8'h04);
    rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
    ir_mode = 2'd0; ext_mode = 1'b0; tick();
  endtask

  task automatic t_timeout();
    ier = 8'h01; fifo_on = 1'b1; rx_nonempty = 1'b1; tick();
    for (int i = 0; i < 3; i++) begin char_tick = 1'b1; tick(); char_tick = 1'b0; tick(); end
    rx_activity = 1'b1; tick(); rx_activity = 1'b0;
    for (int i = 0; i < 3; i++) begin char_tick = 1'b1; tick(); char_tick = 1'b0; tick(); end
    read_chk("R6 activity restarts count", 8'h01);
    char_tick = 1'b1; tick(); char_tick = 1'b0; tick();
    read_chk("R6 time-out after four idle ticks", 8'h0C);
    ext_mode = 1'b1; tick();
    read_chk("R9 time-out on ext bit 0", 8'h01);
    ext_mode = 1'b0;
    rd_rxd = 1'b1; tick(); rd_rxd = 1'b0;
    read_chk("R6 rxd read clears time-out", 8'h01);
    rx_nonempty = 1'b0; fifo_on = 1'b0; tick();
  endtask

  task automatic t_rx_level();
    rx_above = 1'b1; tick();
    read_chk("R5 rising level sets rx", 8'h04);
    rx_above = 1'b0; tick();
    read_chk("R5 falling level clears rx", 8'h01);
  endtask

  task automatic t_side();
    ext_mode = 1'b1; ier = 8'h00; dma_rd_clr = 1'b0; tick();
    dma_ev = 1'b1; tick(); dma_ev = 1'b0;
    read_chk("R11 dma flag set", 8'h10);
    read_chk("R11 read keeps dma without clear-on-read", 8'h10);
    dma_rd_clr = 1'b1;
    read_chk("R11 read returns dma", 8'h10);
    read_chk("R11 read cleared dma", 8'h00);
    dma_rd_clr = 1'b0;
    pld_ev = 1'b1; tick(); pld_ev = 1'b0;
    ier = 8'h20; tick();
    chk("R10 enabled flag drives irq", {7'd0, irq}, 8'h01);
    ier = 8'h40; tick();
    chk("R10 masked flag keeps irq low", {7'd0, irq}, 8'h00);
    side_ack = 4'b0010; tick(); side_ack = 4'b0000;
    sfif_ev = 1'b1; tmr_ev = 1'b1; tick(); sfif_ev = 1'b0; tmr_ev = 1'b0;
    read_chk("R11 ack cleared pld, others set", 8'hC0);
    side_ack = 4'b1100; tick(); side_ack = 4'b0000;
    read_chk("R11 acks clear bits 6 and 7", 8'h00);
    ier = 8'h00; ext_mode = 1'b0; tick();
  endtask

  task automatic t_same_cycle();
    ier = 8'h08; tick();
    modem_chg = 1'b1; rd_msr = 1'b1; tick(); modem_chg = 1'b0; rd_msr = 1'b0;
    read_chk("R12 modem set wins over read", 8'h00);
    rd_msr = 1'b1; tick(); rd_msr = 1'b0;
    read_chk("R12 modem cleared afterwards", 8'h01);
    ext_mode = 1'b1;
    dma_ev = 1'b1; side_ack = 4'b0001; tick(); dma_ev = 1'b0; side_ack = 4'b0000;
    read_chk("R12 dma set wins over ack", 8'h10);
    side_ack = 4'b0001; tick(); side_ack = 4'b0000;
    read_chk("R12 dma acked afterwards", 8'h00);
  endtask

  task automatic t_hold();
    ext_mode = 1'b1; ier = 8'h00; tick();
    modem_chg = 1'b1; tick(); modem_chg = 1'b0; tick();
    chk("R13 read value holds without read", rd_data, 8'h00);
    read_chk("R13 read captures modem", 8'h08);
    rd_msr = 1'b1; tick(); rd_msr = 1'b0; tick();
    chk("R13 held after source cleared", rd_data, 8'h08);
    read_chk("R13 new read shows clear map", 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; ext_mode = 1'b0; fifo_on = 1'b0; dma_rd_clr = 1'b0;
    ir_mode = 2'd0; ier = 8'h00;
    lnk_char_err = 1'b0; lnk_overrun = 1'b0; lnk_frame_end = 1'b0;
    lnk_underrun = 1'b0; lnk_tx_halt = 1'b0;
    rx_above = 1'b0; tx_below = 1'b1; rx_nonempty = 1'b0; rx_activity = 1'b0;
    char_tick = 1'b0; modem_chg = 1'b0; dma_ev = 1'b0; pld_ev = 1'b0;
    sfif_ev = 1'b0; tmr_ev = 1'b0;
    rd_id = 1'b0; rd_lsr = 1'b0; rd_msr = 1'b0; rd_rxd = 1'b0; wr_txd = 1'b0;
    side_ack = 4'b0000;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_priority();
    t_tx_hold();
    t_mask();
    t_submodes();
    t_timeout();
    t_rx_level();
    t_side();
    t_same_cycle();
    t_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule